// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises a host processor through a windowed watchdog. After power-up it stays idle until the host sets an enable bit through its register interface. Once armed, it counts base ticks, which a prescaler derives from the system clock. A 4-bit period code selects a timeout of (code+1) ticks. The host must acknowledge inside a window: after a minimum number of ticks has passed since the last restart, and no later than the expiry tick. A valid acknowledge restarts the count. An acknowledge sent too early is discarded.

If expiry is reached without a valid acknowledge, the block drives its active-low reset/watchdog output low for a fixed number of system clocks. It also drops the armed state, so software must enable it again. A synchronous hard clear input returns everything to the idle state and never produces the reset pulse.

The enable and acknowledge inputs are single-cycle strobes taken from a register interface that lies outside this block.

Top module: `wdt_window`

## Requirements
- R1: After `rst_n` is released, `por_wd_n` is 1 and `wd_armed` is 0, and no pulse occurs while the block is not armed, whatever `wd_ack` does.
- R2: A `wd_en_set` strobe sampled while idle sets `wd_armed` on that edge. The count starts from zero at that edge (edge 0). A strobe sampled while armed or while pulsing has no effect and does not restart the count.
- R3: With no valid acknowledge, `por_wd_n` goes low on clock edge (code+1)*TICK_DIV after the arming or restart edge, where code is `wd_period` (0..15).
- R4: `por_wd_n` stays low for exactly PULSE_CLKS clock cycles, then returns to 1.
- R5: An acknowledge sampled at edge k after the last restart, with k >= MIN_TICKS*TICK_DIV+1 and k <= (code+1)*TICK_DIV, is valid. It restarts the count at edge k, so the next expiry lands on edge k+(code+1)*TICK_DIV.
- R6: An acknowledge sampled at edge k <= MIN_TICKS*TICK_DIV after the last restart is ignored, and the expiry edge does not move.
- R7: At the edge where the pulse begins, `wd_armed` clears. No further pulse follows until a new enable strobe.
- R8: `hard_clr` high at a clock edge makes `por_wd_n` 1 and `wd_armed` 0 after that edge. This ends any pulse in progress and prevents any pending expiry from pulsing.
- R9: An acknowledge sampled on the expiry edge itself counts as valid and wins over the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hard_clr | input | 1 | Synchronous hard clear, active high |
| wd_en_set | input | 1 | Single-cycle strobe: host set the enable bit |
| wd_ack | input | 1 | Single-cycle strobe: host acknowledge |
| wd_period | input | 4 | Timeout code; timeout is code+1 ticks |
| wd_armed | output | 1 | Watchdog enabled and counting |
| por_wd_n | output | 1 | Reset/watchdog pulse output, active low |

## Verification
The assertions take `wd_en_set`, `wd_ack` and `hard_clr` to be synchronous to `clk`. They also take `wd_period` to be held steady while the watchdog is armed, because a code change in mid-count moves the expiry point in a way the properties do not model. The stimulus drives every input on the falling clock edge and changes the period code only between runs, while the block is idle. Enable and acknowledge are always one-cycle strobes placed on chosen edges relative to arming, and the boundary edges of the window are among them.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int TICK_DIV   = 4,
  parameter int MIN_TICKS  = 2,
  parameter int PULSE_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hard_clr,
  input  logic       wd_en_set,
  input  logic       wd_ack,
  input  logic [3:0] wd_period,
  output logic       wd_armed,
  output logic       por_wd_n
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = $clog2(PULSE_CLKS + 1);

  logic [PW-1:0] pre;
  logic [3:0]    tcnt;
  logic [CW-1:0] pcnt;
  logic          armed;
  logic          pulsing;

  wire tick   = armed && (pre == PW'(TICK_DIV - 1));
  wire ack_ok = armed && wd_ack && (int'(tcnt) >= MIN_TICKS);
  wire expire = tick && (tcnt == wd_period) && !ack_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; pulsing <= 1'b0;
      pre <= '0; tcnt <= '0; pcnt <= '0;
    end else if (hard_clr) begin
      armed <= 1'b0; pulsing <= 1'b0;
      pre <= '0; tcnt <= '0; pcnt <= '0;
    end else begin
      if (!armed && !pulsing && wd_en_set) begin
        armed <= 1'b1;
        pre   <= '0;
        tcnt  <= '0;
      end else if (ack_ok) begin
        pre  <= '0;
        tcnt <= '0;
      end else if (expire) begin
        armed   <= 1'b0;
        pulsing <= 1'b1;
        pcnt    <= CW'(PULSE_CLKS - 1);
        pre     <= '0;
        tcnt    <= '0;
      end else if (armed) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) tcnt <= tcnt + 1'b1;
      end
      if (pulsing) begin
        if (pcnt == '0) pulsing <= 1'b0;
        else            pcnt    <= pcnt - 1'b1;
      end
    end
  end

  assign wd_armed = armed;
  assign por_wd_n = !pulsing;
endmodule

module wdt_window_chk #(
  parameter int PULSE_CLKS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic hard_clr,
  input logic wd_en_set,
  input logic wd_armed,
  input logic por_wd_n
);
  int low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= 0;
    else if (!por_wd_n) low_run <= low_run + 1;
    else                low_run <= 0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_armed && por_wd_n) |=> por_wd_n);

  assert_enable_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en_set && !wd_armed && por_wd_n && !hard_clr) |=> wd_armed);

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= PULSE_CLKS);

  assert_disarm_on_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_wd_n) |-> !wd_armed);

  assert_hard_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hard_clr |=> (por_wd_n && !wd_armed));
endmodule

bind wdt_window wdt_window_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hard_clr(hard_clr), .wd_en_set(wd_en_set),
  .wd_armed(wd_armed), .por_wd_n(por_wd_n));

// File: tb/wdt_window_bench.sv
module wdt_window_bench;
  localparam int TICK_DIV = 4, MIN_TICKS = 2, PULSE_CLKS = 8, LIM = 90;

  logic clk = 1'b0, rst_n = 1'b0, hard_clr = 1'b0, wd_en_set = 1'b0, wd_ack = 1'b0;
  logic [3:0] wd_period = 4'd0;
  logic wd_armed, por_wd_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_window #(.TICK_DIV(TICK_DIV), .MIN_TICKS(MIN_TICKS), .PULSE_CLKS(PULSE_CLKS)) u_wdt_window (
    .clk(clk), .rst_n(rst_n), .hard_clr(hard_clr), .wd_en_set(wd_en_set),
    .wd_ack(wd_ack), .wd_period(wd_period), .wd_armed(wd_armed), .por_wd_n(por_wd_n));

  // {code, ack edge (0 = none), expected fall edge}
  localparam int NV = 9;
  localparam int VEC [NV][3] = '{
    '{0, 0, 4}, '{3, 0, 16}, '{15, 0, 64}, '{3, 5, 16}, '{3, 8, 16},
    '{3, 9, 25}, '{3, 16, 32}, '{1, 6, 8}, '{5, 10, 34}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int code, input int ack_at, input int en2_at, input int clr_at,
                     output int fall, output int width);
    fall = 0; width = 0;
    @(negedge clk);
    wd_period = 4'(code);
    wd_en_set = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int k = 1; k <= LIM; k++) begin
      wd_ack    = (k == ack_at);
      wd_en_set = (k == en2_at);
      hard_clr  = (k == clr_at);
      @(posedge clk);
      @(negedge clk);
      if (!por_wd_n) begin
        if (fall == 0) fall = k;
        width++;
      end else if (fall != 0) begin
        break;
      end
    end
    wd_ack = 1'b0; wd_en_set = 1'b0; hard_clr = 1'b0;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int fall, width;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset por_wd_n", por_wd_n, 1);
    check("R1 reset wd_armed", wd_armed, 0);

    begin
      int lows = 0;
      for (int i = 0; i < 40; i++) begin
        wd_ack = i[0];
        @(negedge clk);
        if (!por_wd_n) lows++;
      end
      wd_ack = 1'b0;
      check("R1 ack while idle gives no pulse", lows, 0);
    end

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0], VEC[v][1], 0, 0, fall, width);
      check("R3/R5/R6/R9 fall edge", fall, VEC[v][2]);
      check("R4 pulse width", width, PULSE_CLKS);
      check("R7 disarmed after pulse", wd_armed, 0);
      repeat (3) @(negedge clk);
    end

    run(3, 0, 6, 0, fall, width);
    check("R2 enable while armed ignored", fall, 16);
    repeat (3) @(negedge clk);

    begin
      int lows = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (!por_wd_n) lows++;
      end
      check("R7 no pulse without new enable", lows, 0);
    end

    run(3, 0, 0, 10, fall, width);
    check("R8 hard clear suppresses pulse", fall, 0);
    check("R8 hard clear disarms", wd_armed, 0);

    @(negedge clk);
    wd_period = 4'd0; wd_en_set = 1'b1;
    @(negedge clk);
    wd_en_set = 1'b0;
    repeat (5) @(negedge clk);
    check("R4 pulse active before clear", por_wd_n, 0);
    hard_clr = 1'b1;
    @(negedge clk);
    hard_clr = 1'b0;
    check("R8 clear ends pulse", por_wd_n, 1);
    check("R8 clear leaves disarmed", wd_armed, 0);

    run(2, 0, 0, 0, fall, width);
    check("R2 re-enable after clear", fall, 12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule